// File: doc/BRIEF.md
# Codec configuration sequencer

After reset this block configures an audio codec over a two-wire serial bus without any outside help. It steps through a fixed list of ten register writes held in a small ROM. For each write it sends a start condition and then three bytes: the codec's device address, a register number and a data value. The slave must acknowledge each byte. Both bus lines are open-drain. The block only ever pulls a line low or lets it go, and it reads the data line back through a two-flop synchronizer.

Every bus phase lasts a fixed number of system clocks, set by a parameter. There is no stop condition: a new frame simply opens with a fresh start condition. When an acknowledge does not arrive in its window, or the slave keeps holding the data line after the acknowledge clock, the block counts an error and starts the whole list again from the first write. Once the last write has been acknowledged, the block pulses `done_o` for one cycle and leaves both lines released for good.

Top module: `codec_cfg_seq`

## Requirements
- R1: While `rst_ni` is low, `scl_oe_o` and `sda_oe_o` are 0 (both lines released), `done_o` is 0 and `err_cnt_o` is 0. When reset is released, the sequence starts without any further input.
- R2: A frame opens with a start condition. With both lines released the block waits one phase, pulls SDA low (`sda_oe_o`=1) while SCL is released, waits one phase, pulls SCL low (`scl_oe_o`=1) and waits one more phase. Three bytes then follow, sent MSB first: address 0x34, the register number, and the data value. A 1 bit releases SDA and a 0 bit pulls it low.
- R3: The register and data pairs are sent in this order: (0x0C,0x02), (0x0E,0x03), (0x00,0x17), (0x02,0x17), (0x04,0x79), (0x06,0x79), (0x0A,0x00), (0x08,0x12), (0x10,0xA0), (0x12,0x01).
- R4: Each bit takes three phases of `PHASE_CYC` clocks: SDA is set while SCL is low, SCL is released for one phase, then SCL is pulled for one phase. Every SCL high pulse lasts exactly `PHASE_CYC` clocks, except the one that contains a start condition.
- R5: SDA changes while SCL is released only to pull low for a start condition. No stop condition is ever produced, between frames or after the last one.
- R6: After the eighth bit, SDA is released for one acknowledge phase. If the synchronized SDA is not seen low within that phase, `err_cnt_o` increments and the sequence restarts at the first write with a new start condition.
- R7: The acknowledge phase is followed by one SCL high phase, one SCL low phase and one idle phase. The block then waits up to `ACK_REL_CYC` clocks for SDA to read high. If it does not, `err_cnt_o` increments and the sequence restarts at the first write.
- R8: `err_cnt_o` rises by exactly one for each restart and never changes otherwise.
- R9: After the data byte of the last write is acknowledged and SDA is released, `done_o` is high for exactly one cycle. From the cycle after that pulse, both lines stay released and `done_o` does not rise again until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sda_i | input | 1 | Level on the data line (asynchronous) |
| scl_oe_o | output | 1 | 1 pulls the clock line low, 0 releases it |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |
| done_o | output | 1 | One-cycle pulse when the whole list has been written |
| err_cnt_o | output | ERR_W | Number of restarts since reset |

## Verification
The assertions assume that the only other driver of SDA is a well-behaved slave. Such a slave changes SDA only while SCL is low, so any change on `sda_oe_o` while SCL is released must come from the block. They also assume that `PHASE_CYC` exceeds the synchronizer latency, so that the block's own last data bit has left the synchronizer before the acknowledge is judged. The bench slave pulls or releases SDA only on SCL falling edges. The one exception is the stuck-line scenario, where it keeps SDA low until the block releases SCL to restart. Nack and stuck events are placed at chosen byte positions, so the restart point can be predicted exactly.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int unsigned CFG_WRITES   = 10;
  localparam logic [7:0]  CFG_DEV_ADDR = 8'h34;
  localparam int unsigned SYNC_STAGES  = 2;

  typedef enum logic [3:0] {
    ST_IDLE_HI,  // both released, one phase
    ST_SDA_DN,   // start: sda low, scl high
    ST_SCL_DN,   // start: scl low
    ST_BIT_SET,
    ST_BIT_HI,
    ST_BIT_LO,
    ST_ACK_WAIT,
    ST_ACK_HI,
    ST_ACK_LO,
    ST_ACK_IDLE,
    ST_ACK_REL,
    ST_FINISHED
  } seq_st_e;
endpackage

// File: rtl/cfg_sync2.sv
module cfg_sync2 #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= {2{RST_VAL}};
    else         ff_q <= {ff_q[0], d_i};
  end

  assign q_o = ff_q[1];
endmodule

// File: rtl/cfg_phase_timer.sv
module cfg_phase_timer #(
  parameter int unsigned SHORT_CYC = 32,
  parameter int unsigned LONG_CYC  = 128,
  parameter int unsigned SETTLE    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic long_i,
  output logic expire_o,
  output logic settle_o
);
  localparam int unsigned MAX_CYC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt_q, lim;

  assign lim      = long_i ? CNT_W'(LONG_CYC - 1) : CNT_W'(SHORT_CYC - 1);
  assign expire_o = (cnt_q == lim);
  assign settle_o = (cnt_q >= CNT_W'(SETTLE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i || expire_o)  cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  // R4: a phase never runs past its window
  a_r4_cnt_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= lim);
endmodule

// File: rtl/cfg_rom.sv
module cfg_rom
  import cfg_pkg::*;
#(
  parameter int unsigned IDX_W = $clog2(CFG_WRITES)
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [7:0]       reg_o,
  output logic [7:0]       dat_o
);
  always_comb begin
    case (idx_i)
      IDX_W'(0): {reg_o, dat_o} = {8'h0C, 8'h02};
      IDX_W'(1): {reg_o, dat_o} = {8'h0E, 8'h03};
      IDX_W'(2): {reg_o, dat_o} = {8'h00, 8'h17};
      IDX_W'(3): {reg_o, dat_o} = {8'h02, 8'h17};
      IDX_W'(4): {reg_o, dat_o} = {8'h04, 8'h79};
      IDX_W'(5): {reg_o, dat_o} = {8'h06, 8'h79};
      IDX_W'(6): {reg_o, dat_o} = {8'h0A, 8'h00};
      IDX_W'(7): {reg_o, dat_o} = {8'h08, 8'h12};
      IDX_W'(8): {reg_o, dat_o} = {8'h10, 8'hA0};
      IDX_W'(9): {reg_o, dat_o} = {8'h12, 8'h01};
      default:   {reg_o, dat_o} = 16'h0000;
    endcase
  end
endmodule

// File: rtl/codec_cfg_seq.sv
module codec_cfg_seq
  import cfg_pkg::*;
#(
  parameter int unsigned PHASE_CYC   = 32,
  parameter int unsigned ACK_REL_CYC = 128,
  parameter int unsigned ERR_W       = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sda_i,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  output logic             done_o,
  output logic [ERR_W-1:0] err_cnt_o
);
  localparam int unsigned IDX_W = $clog2(CFG_WRITES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CFG_WRITES - 1);

  seq_st_e          st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [1:0]       byte_q, byte_d;
  logic [2:0]       bit_q, bit_d;
  logic             ack_q, ack_d;
  logic [ERR_W-1:0] err_q, err_d;
  logic             done_q, done_d;
  logic             restart;

  logic       sda_s, tm_exp, tm_settle, tm_clr, ack_seen_now;
  logic [7:0] rom_reg, rom_dat, tx_byte;
  logic       cur_bit;

  cfg_sync2 #(.RST_VAL(1'b1)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sda_i), .q_o(sda_s)
  );

  assign tm_clr = (st_d != st_q);

  cfg_phase_timer #(
    .SHORT_CYC(PHASE_CYC), .LONG_CYC(ACK_REL_CYC), .SETTLE(SYNC_STAGES)
  ) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(tm_clr),
    .long_i(st_q == ST_ACK_REL), .expire_o(tm_exp), .settle_o(tm_settle)
  );

  cfg_rom #(.IDX_W(IDX_W)) u_rom (
    .idx_i(idx_q), .reg_o(rom_reg), .dat_o(rom_dat)
  );

  always_comb begin
    case (byte_q)
      2'd0:    tx_byte = CFG_DEV_ADDR;
      2'd1:    tx_byte = rom_reg;
      default: tx_byte = rom_dat;
    endcase
  end
  assign cur_bit = tx_byte[bit_q];

  // masked until the synchronizer has flushed our own last bit
  assign ack_seen_now = tm_settle && !sda_s;

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    byte_d  = byte_q;
    bit_d   = bit_q;
    ack_d   = ack_q;
    err_d   = err_q;
    done_d  = 1'b0;
    restart = 1'b0;
    case (st_q)
      ST_IDLE_HI: if (tm_exp) st_d = ST_SDA_DN;
      ST_SDA_DN:  if (tm_exp) st_d = ST_SCL_DN;
      ST_SCL_DN: if (tm_exp) begin
        st_d   = ST_BIT_SET;
        byte_d = 2'd0;
        bit_d  = 3'd7;
      end
      ST_BIT_SET: if (tm_exp) st_d = ST_BIT_HI;
      ST_BIT_HI:  if (tm_exp) st_d = ST_BIT_LO;
      ST_BIT_LO: if (tm_exp) begin
        if (bit_q == 3'd0) begin
          st_d  = ST_ACK_WAIT;
          ack_d = 1'b0;
        end else begin
          st_d  = ST_BIT_SET;
          bit_d = bit_q - 1'b1;
        end
      end
      ST_ACK_WAIT: begin
        if (ack_seen_now) ack_d = 1'b1;
        if (tm_exp) begin
          if (ack_q || ack_seen_now) st_d = ST_ACK_HI;
          else                       restart = 1'b1;
        end
      end
      ST_ACK_HI:   if (tm_exp) st_d = ST_ACK_LO;
      ST_ACK_LO:   if (tm_exp) st_d = ST_ACK_IDLE;
      ST_ACK_IDLE: if (tm_exp) st_d = ST_ACK_REL;
      ST_ACK_REL: begin
        if (sda_s) begin
          bit_d = 3'd7;
          if (byte_q == 2'd2) begin
            if (idx_q == LAST_IDX) begin
              st_d   = ST_FINISHED;
              done_d = 1'b1;
            end else begin
              idx_d = idx_q + 1'b1;
              st_d  = ST_IDLE_HI;
            end
          end else begin
            byte_d = byte_q + 1'b1;
            st_d   = ST_BIT_SET;
          end
        end else if (tm_exp) begin
          restart = 1'b1;
        end
      end
      ST_FINISHED: ;
      default: st_d = ST_IDLE_HI;
    endcase
    if (restart) begin
      st_d   = ST_IDLE_HI;
      idx_d  = '0;
      byte_d = 2'd0;
      bit_d  = 3'd7;
      err_d  = err_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE_HI;
      idx_q  <= '0;
      byte_q <= 2'd0;
      bit_q  <= 3'd7;
      ack_q  <= 1'b0;
      err_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      byte_q <= byte_d;
      bit_q  <= bit_d;
      ack_q  <= ack_d;
      err_q  <= err_d;
      done_q <= done_d;
    end
  end

  always_comb begin
    case (st_q)
      ST_SCL_DN, ST_BIT_SET, ST_BIT_LO, ST_ACK_WAIT,
      ST_ACK_LO, ST_ACK_IDLE, ST_ACK_REL:           scl_oe_o = 1'b1;
      default:                                      scl_oe_o = 1'b0;
    endcase
    case (st_q)
      ST_SDA_DN, ST_SCL_DN:                 sda_oe_o = 1'b1;
      ST_BIT_SET, ST_BIT_HI, ST_BIT_LO:     sda_oe_o = !cur_bit;
      default:                              sda_oe_o = 1'b0;
    endcase
  end

  assign done_o    = done_q;
  assign err_cnt_o = err_q;

  // R5: with SCL released, SDA may only move to a pull (start), never release (stop)
  a_r5_no_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_oe_o && !$past(scl_oe_o) && (sda_oe_o != $past(sda_oe_o))) |-> sda_oe_o);

  // R8: error count moves only by single increments
  a_r8_err_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_cnt_o != $past(err_cnt_o)) |-> (err_cnt_o == ERR_W'($past(err_cnt_o) + 1'b1)));

  // R9: done is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9: bus released once the list is finished
  a_r9_idle_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(done_o) |-> (!scl_oe_o && !sda_oe_o));

  // R3: write index never leaves the ROM
  a_r3_idx_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= LAST_IDX);
endmodule

// File: tb/codec_cfg_seq_tb_top.sv
module codec_cfg_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int P   = 4;
  localparam int REL = 16;
  localparam int NB  = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sda_bus;
  logic scl_oe, sda_oe, done;
  logic [7:0] err_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  codec_cfg_seq #(.PHASE_CYC(P), .ACK_REL_CYC(REL), .ERR_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sda_i(sda_bus),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .done_o(done), .err_cnt_o(err_cnt)
  );

  // slave model state
  logic sl_pull, sl_hold, sl_stuck;
  logic prev_scl, prev_sda, hi_has_start;
  logic [7:0] sh;
  logic [7:0] rx [0:63];
  int bitc, rx_n, starts, stops, bad_w, hi_w, done_cnt;
  int nack_a, nack_b, stuck_at;

  assign sda_bus = !(sda_oe || sl_pull);

  logic [7:0] exp_reg [0:9];
  logic [7:0] exp_dat [0:9];
  int total = 0, fails = 0;

  function automatic logic [7:0] exp_byte(int i);
    if (i % 3 == 0) return 8'h34;
    if (i % 3 == 1) return exp_reg[i/3];
    return exp_dat[i/3];
  endfunction

  always @(negedge clk) begin
    logic scl, sda;
    scl = !scl_oe;
    sda = !(sda_oe || sl_pull);
    if (!rst_n) begin
      sl_pull = 0; sl_hold = 0; sl_stuck = 0; bitc = 0; rx_n = 0;
      starts = 0; stops = 0; bad_w = 0; hi_w = 0; done_cnt = 0;
      hi_has_start = 0; prev_scl = 1; prev_sda = 1; sh = 0;
    end else begin
      if (done) done_cnt++;
      if (scl && prev_scl && prev_sda && !sda) begin
        starts++; bitc = 0; hi_has_start = 1;
      end else if (scl && prev_scl && !prev_sda && sda) begin
        stops++;
      end
      if (scl) hi_w++;
      if (scl && !prev_scl) begin
        if (sl_hold) begin
          sl_pull = 0; sl_hold = 0;
        end else if (bitc < 8) begin
          sh = {sh[6:0], sda}; bitc++;
        end else if (bitc == 9) begin
          bitc = 10;
        end
      end else if (!scl && prev_scl) begin
        if (!hi_has_start && hi_w != P) bad_w++;
        hi_w = 0; hi_has_start = 0;
        if (bitc == 8) begin
          rx[rx_n] = sh;
          sl_stuck = (rx_n == stuck_at);
          if (rx_n != nack_a && rx_n != nack_b) sl_pull = 1;
          rx_n++;
          bitc = 9;
        end else if (bitc == 10) begin
          if (sl_stuck) begin
            sl_hold = 1; sl_stuck = 0;
          end else begin
            sl_pull = 0;
          end
          bitc = 0;
        end
      end
      prev_scl = scl;
      prev_sda = !(sda_oe || sl_pull);
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic do_reset(input int na, input int nb, input int st);
    nack_a = na; nack_b = nb; stuck_at = st;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (done_cnt == 0 && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(done_cnt != 0, tag, n, 20000);
    repeat (50) @(negedge clk);
  endtask

  task automatic check_tail(input int base, input string tag);
    for (int i = 0; i < NB; i++)
      chk(rx[base+i] == exp_byte(i), tag, int'(rx[base+i]), int'(exp_byte(i)));
  endtask

  task automatic t_reset();
    nack_a = -1; nack_b = -1; stuck_at = -1;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(scl_oe == 1'b0, "R1 scl released", int'(scl_oe), 0);
    chk(sda_oe == 1'b0, "R1 sda released", int'(sda_oe), 0);
    chk(done == 1'b0, "R1 done low", int'(done), 0);
    chk(err_cnt == 8'd0, "R1 err zero", int'(err_cnt), 0);
  endtask

  task automatic t_normal();
    do_reset(-1, -1, -1);
    wait_done("R1 self-start reaches done");
    chk(rx_n == NB, "R3 byte count", rx_n, NB);
    check_tail(0, "R3 byte value");
    chk(starts == 10, "R2 start conditions", starts, 10);
    chk(stops == 0, "R5 no stop", stops, 0);
    chk(bad_w == 0, "R4 scl high width", bad_w, 0);
    chk(err_cnt == 8'd0, "R8 no errors", int'(err_cnt), 0);
    chk(done_cnt == 1, "R9 done once", done_cnt, 1);
    chk(!scl_oe && !sda_oe, "R9 lines idle", int'({scl_oe, sda_oe}), 0);
  endtask

  task automatic t_nack();
    do_reset(4, -1, -1);
    wait_done("R6 done after nack");
    chk(err_cnt == 8'd1, "R6 err count", int'(err_cnt), 1);
    chk(rx_n == 5 + NB, "R6 byte count", rx_n, 5 + NB);
    for (int i = 0; i < 5; i++)
      chk(rx[i] == exp_byte(i), "R6 prefix", int'(rx[i]), int'(exp_byte(i)));
    check_tail(5, "R6 restarted from first write");
    chk(starts == 12, "R6 start count", starts, 12);
    chk(done_cnt == 1, "R9 done once after nack", done_cnt, 1);
  endtask

  task automatic t_stuck();
    do_reset(-1, -1, 8);
    wait_done("R7 done after stuck");
    chk(err_cnt == 8'd1, "R7 err count", int'(err_cnt), 1);
    chk(rx_n == 9 + NB, "R7 byte count", rx_n, 9 + NB);
    check_tail(9, "R7 restarted from first write");
    chk(starts == 13, "R7 start count", starts, 13);
  endtask

  task automatic t_double();
    do_reset(0, 1, -1);
    wait_done("R8 done after two nacks");
    chk(err_cnt == 8'd2, "R8 err count", int'(err_cnt), 2);
    chk(rx_n == 2 + NB, "R8 byte count", rx_n, 2 + NB);
    check_tail(2, "R8 final pass");
  endtask

  initial begin
    exp_reg[0] = 8'h0C; exp_dat[0] = 8'h02;
    exp_reg[1] = 8'h0E; exp_dat[1] = 8'h03;
    exp_reg[2] = 8'h00; exp_dat[2] = 8'h17;
    exp_reg[3] = 8'h02; exp_dat[3] = 8'h17;
    exp_reg[4] = 8'h04; exp_dat[4] = 8'h79;
    exp_reg[5] = 8'h06; exp_dat[5] = 8'h79;
    exp_reg[6] = 8'h0A; exp_dat[6] = 8'h00;
    exp_reg[7] = 8'h08; exp_dat[7] = 8'h12;
    exp_reg[8] = 8'h10; exp_dat[8] = 8'hA0;
    exp_reg[9] = 8'h12; exp_dat[9] = 8'h01;
    t_reset();
    t_normal();
    t_nack();
    t_stuck();
    t_double();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule